// File: doc/BRIEF.md
# Channel Burst Issue Scheduler

This block picks which of several burst sources sends its next burst to a single memory channel, and it keeps a bound on how many bursts are outstanding on that channel. One instance is placed per channel. Each source offers a burst tag on a valid/ready port. The scheduler chooses one eligible source and presents its tag on the issue port. A burst is accepted when the channel raises its ready. Completions come back carrying the tag of the finished burst. They free the tag and lower the outstanding count.

The base policy is round-robin. A source that has waited for `AGE_LIMIT` or more cycles without being served counts as aged. Aged sources take priority over young ones, and among several aged sources the round-robin pointer settles the order. No offered burst can therefore be passed over forever. A tag that is still outstanding cannot be issued a second time, so the source offering it waits until that tag has been retired. A completion carrying a tag that is not outstanding sets a sticky error flag.

Top module: `chan_burst_sched`

## Requirements
- R1: After synchronous reset the outstanding count is 0, the error flag is 0, all tags are free, all waiting ages are 0 and the round-robin pointer is at source 0.
- R2: `iss_valid` is high exactly when at least one source is eligible and the count is below `MAX_INFLIGHT`. `req_ready` is one-hot or zero, and it goes high only for the selected source and only when `iss_ready` is high.
- R3: While the count equals `MAX_INFLIGHT` no burst is issued, and the count never exceeds `MAX_INFLIGHT`, whose legal range is 8 to 16.
- R4: The count rises by 1 for each accepted issue and falls by 1 for each completion whose tag is outstanding. When both happen in the same cycle the count is unchanged.
- R5: When no eligible source is aged, the selected source is the first eligible one found scanning upward, with wraparound, from the round-robin pointer.
- R6: The pointer moves to one past the granted source index, wrapping to 0, only in a cycle where an issue is accepted. Otherwise it holds.
- R7: A source that has been valid for `AGE_LIMIT` consecutive edges without a grant is aged. Any eligible aged source wins over every young one, and ties among aged sources follow the round-robin scan order.
- R8: A source whose offered tag is still outstanding is not eligible. It becomes eligible in the cycle after that tag completes.
- R9: A completion whose tag is not outstanding sets `cpl_err` from the next cycle on until reset, and it leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NUM_REQ | Per-source burst offer |
| req_id | input | NUM_REQ*ID_W | Per-source burst tag; source i uses bits [i*ID_W +: ID_W] |
| req_ready | output | NUM_REQ | Per-source acceptance |
| iss_valid | output | 1 | Burst presented to the channel |
| iss_id | output | ID_W | Tag of the presented burst |
| iss_src | output | SRC_W | Index of the selected source |
| iss_ready | input | 1 | Channel accepts the presented burst |
| cpl_valid | input | 1 | Completion strobe |
| cpl_id | input | ID_W | Tag of the completed burst |
| inflight | output | CNT_W | Outstanding burst count |
| cpl_err | output | 1 | Sticky flag for a completion with an unknown tag |

## Verification
The bench first drives all four sources at once with the channel always ready. This shows a strict rotation, and it also fills the cap at exactly eight outstanding bursts. It then stalls the channel while one or two sources are kept waiting and younger sources arrive afterwards. A selection that departs from pointer order can only come from aging, and a pair of aged sources shows how ties are broken. Single-event patterns cover the remaining cases: a completion on its own, a completion in the same cycle as an issue, a completion with an unknown tag, and an offered tag that is still outstanding. Each of these separates the count, error and eligibility rules from one another.

// File: rtl/sched_pkg.sv
package sched_pkg;
    // Legal bounds for the per-channel outstanding cap.
    localparam int unsigned INFLIGHT_MIN = 8;
    localparam int unsigned INFLIGHT_MAX = 16;

    // Index width for a set of n items (at least 1 bit).
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = sched_pkg::idx_w(N)
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    // First set bit of mask at or after start, wrapping around.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < int'(N); k++) begin
            int j;
            j = (int'(start) + k) % int'(N);
            if (!found && mask[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/sched_age_track.sv
module sched_age_track #(
    parameter int unsigned N         = 4,
    parameter int unsigned AGE_LIMIT = 4,
    localparam int unsigned AGE_W    = $clog2(AGE_LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] waiting,
    input  logic [N-1:0] granted,
    output logic [N-1:0] aged
);
    localparam logic [AGE_W-1:0] LIM = AGE_W'(AGE_LIMIT);

    typedef struct packed {
        logic [N-1:0][AGE_W-1:0] age;
    } age_st_t;

    age_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(N); i++) begin
            if (!waiting[i] || granted[i]) begin
                st_d.age[i] = '0;
            end else if (st_q.age[i] != LIM) begin
                st_d.age[i] = st_q.age[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_aged
        assign aged[g] = (st_q.age[g] == LIM);

        AST_AGE_RESET_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
            granted[g] |=> !aged[g]); // R7
    end
endmodule

// File: rtl/sched_out_track.sv
module sched_out_track #(
    parameter int unsigned ID_W         = 4,
    parameter int unsigned MAX_INFLIGHT = 8,
    localparam int unsigned NTAG        = 1 << ID_W,
    localparam int unsigned CNT_W       = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_fire,
    input  logic [ID_W-1:0]  iss_tag,
    input  logic             cpl_valid,
    input  logic [ID_W-1:0]  cpl_tag,
    output logic [NTAG-1:0]  busy,
    output logic [CNT_W-1:0] count,
    output logic             err
);
    typedef struct packed {
        logic [NTAG-1:0]  busy;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } out_st_t;

    out_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d = st_q;
        hit  = cpl_valid && st_q.busy[cpl_tag];
        if (hit)                     st_d.busy[cpl_tag] = 1'b0;
        if (iss_fire)                st_d.busy[iss_tag] = 1'b1;
        if (cpl_valid && !hit)       st_d.err           = 1'b1;
        if (iss_fire && !hit)        st_d.cnt           = st_q.cnt + 1'b1;
        else if (!iss_fire && hit)   st_d.cnt           = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign count = st_q.cnt;
    assign err   = st_q.err;

    AST_CNT_MATCHES_TAGS: assert property (@(posedge clk) disable iff (rst)
        int'(count) == $countones(busy)); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R9
    AST_NO_REISSUE: assert property (@(posedge clk) disable iff (rst)
        iss_fire |-> !busy[iss_tag]); // R8
endmodule

// File: rtl/chan_burst_sched.sv
module chan_burst_sched #(
    parameter int unsigned NUM_REQ      = 4,
    parameter int unsigned ID_W         = 4,
    parameter int unsigned MAX_INFLIGHT = 8,
    parameter int unsigned AGE_LIMIT    = 4,
    localparam int unsigned SRC_W       = sched_pkg::idx_w(NUM_REQ),
    localparam int unsigned CNT_W       = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_REQ-1:0]      req_valid,
    input  logic [NUM_REQ*ID_W-1:0] req_id,
    output logic [NUM_REQ-1:0]      req_ready,
    output logic                    iss_valid,
    output logic [ID_W-1:0]         iss_id,
    output logic [SRC_W-1:0]        iss_src,
    input  logic                    iss_ready,
    input  logic                    cpl_valid,
    input  logic [ID_W-1:0]         cpl_id,
    output logic [CNT_W-1:0]        inflight,
    output logic                    cpl_err
);
    localparam int unsigned     NTAG  = 1 << ID_W;
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(MAX_INFLIGHT);
    localparam logic [SRC_W-1:0] LAST = SRC_W'(NUM_REQ - 1);

    if (MAX_INFLIGHT < sched_pkg::INFLIGHT_MIN || MAX_INFLIGHT > sched_pkg::INFLIGHT_MAX) begin : g_bad_cap
        $error("MAX_INFLIGHT outside the legal range"); // R3
    end

    typedef struct packed {
        logic [SRC_W-1:0] ptr;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NTAG-1:0]    busy;
    logic [NUM_REQ-1:0] eligible, aged, old_mask;
    logic               old_found, any_found, fire;
    logic [SRC_W-1:0]   old_idx, any_idx, pick;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_elig
        assign eligible[g] = req_valid[g] && !busy[req_id[g*ID_W +: ID_W]];
    end
    assign old_mask = eligible & aged;

    sched_rr_pick #(.N(NUM_REQ), .IW(SRC_W)) u_pick_old (
        .mask(old_mask), .start(st_q.ptr), .found(old_found), .idx(old_idx)
    );
    sched_rr_pick #(.N(NUM_REQ), .IW(SRC_W)) u_pick_any (
        .mask(eligible), .start(st_q.ptr), .found(any_found), .idx(any_idx)
    );

    always_comb begin
        st_d      = st_q;
        pick      = old_found ? old_idx : any_idx;
        iss_valid = any_found && (inflight < CAP);
        fire      = iss_valid && iss_ready;
        req_ready = '0;
        if (fire) begin
            req_ready[pick] = 1'b1;
            st_d.ptr        = (pick == LAST) ? '0 : pick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign iss_src = pick;
    assign iss_id  = req_id[pick*ID_W +: ID_W];

    sched_age_track #(.N(NUM_REQ), .AGE_LIMIT(AGE_LIMIT)) u_age (
        .clk(clk), .rst(rst), .waiting(req_valid), .granted(req_ready), .aged(aged)
    );

    sched_out_track #(.ID_W(ID_W), .MAX_INFLIGHT(MAX_INFLIGHT)) u_out (
        .clk(clk), .rst(rst), .iss_fire(fire), .iss_tag(iss_id),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_id),
        .busy(busy), .count(inflight), .err(cpl_err)
    );

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (rst)
        inflight <= CAP); // R3
    AST_NO_ISSUE_FULL: assert property (@(posedge clk) disable iff (rst)
        (inflight == CAP) |-> !iss_valid); // R3
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready)); // R2
    AST_READY_NEEDS_CHAN: assert property (@(posedge clk) disable iff (rst)
        (req_ready != '0) |-> (iss_ready && iss_valid)); // R2
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_ready == '0) |=> $stable(st_q.ptr)); // R6
    AST_CNT_UP: assert property (@(posedge clk) disable iff (rst)
        ((req_ready != '0) && !cpl_valid) |=> (inflight == $past(inflight) + 1'b1)); // R4
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_ast
        AST_READY_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
            req_ready[g] |-> req_valid[g]); // R2
    end
endmodule

// File: tb/chan_burst_sched_tb.sv
module chan_burst_sched_tb;
    localparam int N = 4, IDW = 4, CAPV = 8, AGEL = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic [N-1:0]     req_valid = '0;
    logic [N*IDW-1:0] req_id    = '0;
    logic [N-1:0]     req_ready;
    logic             iss_valid, iss_ready = 1'b0, cpl_valid = 1'b0;
    logic [IDW-1:0]   iss_id, cpl_id = '0;
    logic [1:0]       iss_src;
    logic [3:0]       inflight;
    logic             cpl_err;

    int n_run = 0, n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    chan_burst_sched #(.NUM_REQ(N), .ID_W(IDW), .MAX_INFLIGHT(CAPV), .AGE_LIMIT(AGEL)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id), .req_ready(req_ready),
        .iss_valid(iss_valid), .iss_id(iss_id), .iss_src(iss_src), .iss_ready(iss_ready),
        .cpl_valid(cpl_valid), .cpl_id(cpl_id), .inflight(inflight), .cpl_err(cpl_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic offer(input int i, input int id);
        req_valid[i] = 1'b1;
        req_id[i*IDW +: IDW] = IDW'(id);
    endtask

    task automatic do_reset();
        rst = 1'b1; req_valid = '0; iss_ready = 1'b0; cpl_valid = 1'b0;
        step(); step();
        rst = 1'b0;
        settle();
        chk("R1", "count after reset", int'(inflight), 0);
        chk("R1", "err after reset", int'(cpl_err), 0);
        chk("R1", "iss_valid after reset", int'(iss_valid), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 5000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int k [N];
        do_reset();

        // Rotation and cap fill: all sources always valid, channel always ready.
        for (int i = 0; i < N; i++) k[i] = 0;
        iss_ready = 1'b1;
        for (int n = 0; n < CAPV; n++) begin
            for (int i = 0; i < N; i++) offer(i, i + 4 * k[i]);
            settle();
            chk("R2", "iss_valid while filling", int'(iss_valid), 1);
            chk("R5", "rotation source", int'(iss_src), n % N);
            chk("R6", "rotation tag", int'(iss_id), (n % N) + 4 * (n / N));
            chk("R2", "ready one-hot", int'(req_ready), 1 << (n % N));
            k[n % N]++;
            step();
            chk("R4", "count rises", int'(inflight), n + 1);
        end
        for (int i = 0; i < N; i++) offer(i, i + 8);
        settle();
        chk("R3", "no issue at cap", int'(iss_valid), 0);
        chk("R3", "no ready at cap", int'(req_ready), 0);
        step();
        chk("R3", "count held at cap", int'(inflight), CAPV);
        req_valid = '0;

        // Lone completion.
        cpl_valid = 1'b1; cpl_id = 4'd2;
        step();
        cpl_valid = 1'b0;
        chk("R4", "count after completion", int'(inflight), 7);

        // Issue and completion together (pointer back at 0).
        offer(0, 8);
        cpl_valid = 1'b1; cpl_id = 4'd3;
        settle();
        chk("R6", "pointer wrapped to 0", int'(iss_src), 0);
        step();
        cpl_valid = 1'b0; req_valid = '0;
        chk("R4", "count unchanged on issue+completion", int'(inflight), 7);

        // Unknown tag.
        cpl_valid = 1'b1; cpl_id = 4'd15;
        step();
        cpl_valid = 1'b0;
        chk("R9", "err after unknown tag", int'(cpl_err), 1);
        chk("R9", "count after unknown tag", int'(inflight), 7);
        step();
        chk("R9", "err sticky", int'(cpl_err), 1);

        // Tag still outstanding blocks its source.
        offer(1, 4);
        settle();
        chk("R8", "busy tag not issued", int'(iss_valid), 0);
        cpl_valid = 1'b1; cpl_id = 4'd4;
        step();
        cpl_valid = 1'b0;
        settle();
        chk("R8", "freed tag issued", int'(iss_valid), 1);
        chk("R8", "freed tag source", int'(iss_src), 1);
        step();
        req_valid = '0;
        chk("R4", "count after free and reissue", int'(inflight), 7);

        // Aged source beats pointer order.
        do_reset();
        offer(3, 3);
        for (int c = 0; c < 5; c++) step();
        offer(0, 0);
        settle();
        chk("R7", "aged source wins", int'(iss_src), 3);
        chk("R2", "no ready while channel stalls", int'(req_ready), 0);
        step();
        settle();
        chk("R6", "pointer holds on stall", int'(iss_src), 3);
        iss_ready = 1'b1;
        settle();
        chk("R7", "aged source accepted", int'(req_ready), 8);
        step();
        req_valid[3] = 1'b0;
        settle();
        chk("R5", "young source after aged", int'(iss_src), 0);
        step();
        req_valid = '0;
        chk("R4", "count after two issues", int'(inflight), 2);

        // Two aged sources: tie by pointer, then aging overrides pointer again.
        do_reset();
        offer(1, 1); offer(3, 3);
        for (int c = 0; c < 5; c++) step();
        offer(0, 0); offer(2, 2);
        settle();
        chk("R7", "aged tie by pointer", int'(iss_src), 1);
        iss_ready = 1'b1;
        step();
        req_valid[1] = 1'b0;
        settle();
        chk("R7", "remaining aged beats pointer", int'(iss_src), 3);
        step();
        req_valid[3] = 1'b0;
        settle();
        chk("R5", "pointer order after aged", int'(iss_src), 0);
        step();
        req_valid[0] = 1'b0;
        settle();
        chk("R5", "last young source", int'(iss_src), 2);
        step();
        req_valid = '0;
        chk("R4", "count after four issues", int'(inflight), 4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule